// File: doc/BRIEF.md
# Clear-to-send change-of-state interrupt unit

This block watches the active-low clear-to-send line of one serial channel and raises an interrupt when that line changes level for long enough to count. The raw input passes through a two-flop synchroniser and then a debounce filter. The filter counts sample strobes and accepts a new level only after the level has held for `FILT_TICKS` of them. An accepted change sets a change-of-state flag. An input-enable bit decides whether that flag also reaches the interrupt status. A mask then decides whether the status drives the interrupt output.

Software reaches the block through a single-cycle byte register bus. Address 0 is the read-only port-change register, and reading it clears the change-of-state flag. Address 1 is the write-only auxiliary control register that holds the input-enable bit. Address 2 gives interrupt status on a read and takes mask bits on a write. A serial-clock strobe times the start-up sample: two strobes after reset, the current-state bit begins to follow the filtered input. If the line is asserted at that moment, the change-of-state flag sets without any transition.

Top module: `cts_cos_irq`

## Requirements
- R1: The filtered level changes only after the synchronised input differs from it on `FILT_TICKS` consecutive `sample_tick` strobes. A return to the old level restarts the count, so shorter pulses have no effect.
- R2: A read of address 0 clears the change-of-state flag and the status change-of-state bit. If a new change-of-state event occurs in the same cycle, both stay set.
- R3: Until the second `sclk_tick` after reset, bit 0 of address 0 reads 1. On that second tick, a filtered level of low (asserted) sets the change-of-state flag.
- R4: Address 0 reads bit 4 as the change-of-state flag and bit 0 as the current state (0 asserted/low, 1 deasserted). All other bits read 0.
- R5: Address 1 is write-only and reads 0. Its bit 0 is the input-enable control, which resets to 0.
- R6: A change-of-state event sets the status change-of-state bit (bit 3 of address 2) only while the input-enable control is 1.
- R7: `irq` is 1 exactly when some status bit and its mask bit are both 1. The mask resets to 0.
- R8: A read of address 2 returns the status byte. A write to address 2 replaces the mask byte.
- R9: `rdata` is registered: it carries the addressed value in the cycle after `rd_en` is high, and 0 after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Filter sample strobe |
| sclk_tick | input | 1 | Serial clock strobe for the start-up sample |
| cts_n_in | input | 1 | Raw clear-to-send input, active low |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with `FILT_TICKS` set to 3 instead of the default 16. A level held for only one or two strobes is rejected, while one held for three is accepted. Both cases occur often under random toggling of the input and random strobe density. At this setting a glitch ending exactly at the threshold, and a filtered change landing in the same cycle as a clearing read, both come up within a few thousand cycles.

// File: rtl/cts_cos_irq.sv
module cts_cos_irq #(
  parameter int FILT_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       sclk_tick,
  input  logic       cts_n_in,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int CW = $clog2(FILT_TICKS + 1);

  logic [1:0]    sync;
  logic          acc;
  logic [CW-1:0] cnt;
  logic [1:0]    scnt;
  logic          started;
  logic          cos_flag, stat_cos, iec;
  logic [7:0]    mask;

  wire lvl        = sync[1];
  wire filt_evt   = (lvl != acc) && sample_tick && (cnt == CW'(FILT_TICKS - 1));
  wire start_puls = !started && sclk_tick && (scnt == 2'd1);
  wire cos_set    = (start_puls && !acc) || (filt_evt && started);
  wire clr        = rd_en && (addr == 2'd0);
  wire cts_bit    = started ? acc : 1'b1;
  wire [7:0] status = {4'b0, stat_cos, 3'b0};

  assign irq = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      acc  <= 1'b1;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], cts_n_in};
      if (lvl == acc)
        cnt <= '0;
      else if (sample_tick) begin
        if (filt_evt) begin
          acc <= lvl;
          cnt <= '0;
        end else
          cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt    <= '0;
      started <= 1'b0;
    end else if (!started && sclk_tick) begin
      scnt <= scnt + 1'b1;
      if (start_puls) started <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cos_flag <= 1'b0;
      stat_cos <= 1'b0;
      iec      <= 1'b0;
      mask     <= '0;
      rdata    <= '0;
    end else begin
      if (cos_set)  cos_flag <= 1'b1;
      else if (clr) cos_flag <= 1'b0;
      if (cos_set && iec) stat_cos <= 1'b1;
      else if (clr)       stat_cos <= 1'b0;
      if (wr_en && addr == 2'd1) iec  <= wdata[0];
      if (wr_en && addr == 2'd2) mask <= wdata;
      if (!rd_en)              rdata <= '0;
      else if (addr == 2'd0)   rdata <= {3'b0, cos_flag, 3'b0, cts_bit};
      else if (addr == 2'd2)   rdata <= status;
      else                     rdata <= '0;
    end
  end
endmodule

// File: rtl/cts_cos_irq_chk.sv
module cts_cos_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       rd_en,
  input logic       sample_tick,
  input logic [7:0] rdata,
  input logic       irq,
  input logic [7:0] mask,
  input logic       cos_flag,
  input logic       stat_cos,
  input logic       iec,
  input logic       acc,
  input logic       started,
  input logic       cos_set
);
  AST_FILT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(acc)); // R1
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && !cos_set) |=> !cos_flag && !stat_cos); // R2
  AST_CTS_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && !started) |=> rdata[0]); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:5] == 3'b0 && rdata[2:1] == 2'b0); // R4
  AST_STATUS_NEEDS_IEC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_cos) |-> $past(iec)); // R6
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask != 8'h00); // R7
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == 8'h00); // R9
endmodule

bind cts_cos_irq cts_cos_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
  .sample_tick(sample_tick), .rdata(rdata), .irq(irq), .mask(mask),
  .cos_flag(cos_flag), .stat_cos(stat_cos), .iec(iec), .acc(acc),
  .started(started), .cos_set(cos_set)
);

// File: tb/cts_cos_irq_bench.sv
module cts_cos_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FT = 3;

  logic clk = 0, rst_n = 0, sample_tick = 0, sclk_tick = 0, cts_n_in = 1;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cts_cos_irq #(.FILT_TICKS(FT)) u_cts_cos_irq (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .sclk_tick(sclk_tick),
    .cts_n_in(cts_n_in), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  // Reference state built from the requirements
  logic [1:0] m_sync;
  logic m_lvl, m_flag, m_stat, m_iec, m_started;
  int m_run, m_sclk;
  logic [7:0] m_mask, m_rdata;
  logic [1:0] m_last_addr;

  function automatic logic [7:0] port_byte(logic flag, logic cts);
    return {3'b0, flag, 3'b0, cts};
  endfunction

  function automatic logic [7:0] stat_byte(logic s);
    return {4'b0, s, 3'b0};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 2'b11; m_lvl = 1; m_run = 0; m_sclk = 0; m_started = 0;
      m_flag = 0; m_stat = 0; m_iec = 0; m_mask = 0; m_rdata = 0; m_last_addr = 0;
    end else begin
      logic accept, start, ev, newlvl;
      accept = 0; newlvl = m_lvl;
      if (m_sync[1] == m_lvl) m_run = 0;
      else if (sample_tick) begin
        m_run++;
        if (m_run == FT) begin accept = 1; newlvl = m_sync[1]; m_run = 0; end
      end
      start = !m_started && sclk_tick && m_sclk == 1;
      ev = (start && !m_lvl) || (accept && m_started);
      m_rdata = !rd_en ? 8'h00 :
                addr == 0 ? port_byte(m_flag, m_started ? m_lvl : 1'b1) :
                addr == 2 ? stat_byte(m_stat) : 8'h00;
      m_last_addr = addr;
      if (ev) m_flag = 1; else if (rd_en && addr == 0) m_flag = 0;
      if (ev && m_iec) m_stat = 1; else if (rd_en && addr == 0) m_stat = 0;
      if (wr_en && addr == 1) m_iec = wdata[0];
      if (wr_en && addr == 2) m_mask = wdata;
      if (!m_started && sclk_tick) m_sclk++;
      if (start) m_started = 1;
      m_lvl = newlvl;
      m_sync = {m_sync[0], cts_n_in};
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cycle_check();
    @(negedge clk);
    chk("R7 irq", {7'b0, irq}, {7'b0, |(stat_byte(m_stat) & m_mask)});
    chk(m_last_addr == 0 ? "R4 R2 R3 R9 rdata" :
        m_last_addr == 2 ? "R8 R6 rdata" : "R5 R9 rdata", rdata, m_rdata);
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    // Directed: start-up with line asserted
    cts_n_in = 0;
    repeat (3) @(negedge clk);
    chk("R7 reset irq", {7'b0, irq}, 8'h00);
    chk("R9 reset rdata", rdata, 8'h00);
    rst_n = 1;
    sample_tick = 1;
    rd_en = 1; addr = 0;
    cycle_check();
    chk("R3 before start", rdata, 8'h01);
    idle();
    repeat (6) cycle_check();
    sclk_tick = 1; cycle_check(); cycle_check(); sclk_tick = 0;
    rd_en = 1; addr = 0; cycle_check();
    chk("R3 start sets flag", rdata, 8'h10);
    rd_en = 1; cycle_check();
    chk("R2 cleared by read", rdata, 8'h00);
    idle();
    rd_en = 1; addr = 1; cycle_check();
    chk("R5 write-only reads 0", rdata, 8'h00);
    // Directed: enable, mask, glitch, real change
    wr_en = 1; rd_en = 0; addr = 1; wdata = 8'h01; cycle_check();
    addr = 2; wdata = 8'h08; cycle_check();
    idle();
    cts_n_in = 1; cycle_check(); cts_n_in = 0;
    repeat (8) cycle_check();
    chk("R1 glitch ignored irq", {7'b0, irq}, 8'h00);
    cts_n_in = 1; repeat (8) cycle_check();
    chk("R6 R7 change raises irq", {7'b0, irq}, 8'h01);
    rd_en = 1; addr = 2; cycle_check();
    chk("R8 status read", rdata, 8'h08);
    idle();
    // Random phase
    for (int i = 0; i < 20000; i++) begin
      int op;
      sample_tick = ($urandom_range(0, 1) == 1);
      sclk_tick   = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 5) == 0) cts_n_in = ~cts_n_in;
      op = $urandom_range(0, 9);
      wr_en = 0; rd_en = 0;
      addr = 2'($urandom_range(0, 3));
      wdata = 8'($urandom);
      if (op < 3) rd_en = 1;
      else if (op == 3) wr_en = 1;
      if (i % 5000 == 4999) begin
        rst_n = 0; cycle_check(); rst_n = 1;
      end
      cycle_check();
    end
    idle();
    cycle_check();
    done = 1;
    finish_run();
  end
endmodule